// File: doc/BRIEF.md
# Character Row Fetch Sequencer

This block drives the video memory bus of a character-mode display generator for one scanline at a time. A free-running cycle counter splits every scanline into a fixed number of bus cycles. Inside a window that opens at a programmable horizontal position, the block fetches each text column in two back-to-back cycles. The first cycle reads the character code from screen memory, and the colour nibble comes back from a separate colour memory in that same cycle. The second cycle reads one glyph row from character memory. The glyph byte is loaded into a shifter that sends four pixels to the output on each bus cycle, so one column slot shows eight pixels.

The column count, window start, glyph height and the line-active flag from the vertical logic are captured once per scanline. A row-within-glyph counter moves forward after every active line. When that counter wraps, the text-row base address moves on by the full programmed column count. This holds even when part of the programmed row was cut off because it ran past the end of the line or past the visible area.

A four-state machine sets the fetch order. ST_LEAD waits for the window to open. ST_CODE issues a code fetch and always goes on to ST_GLYPH. ST_GLYPH issues a glyph fetch and goes back to ST_CODE while columns remain, or to ST_TRAIL after the last column. ST_TRAIL idles until the line ends. On the last cycle of every line the machine goes to ST_CODE if the next line is active, has at least one column and its window starts at cycle 0. Otherwise it goes to ST_LEAD.

Top module: `charfetch_seq`

## Requirements
- R1: The cycle counter runs from 0 to 70 and then wraps, so every line is exactly 71 cycles long whatever the configuration. The counter reads 0 in the first cycle after reset is released. Column k of a line is fetched with its code at cycle h_start+2k and its glyph at cycle h_start+2k+1, and h_start may be 0.
- R2: In a code cycle, code_strobe is 1 and fetch_addr equals the text-row base plus the column index, modulo 2^14. color_data is captured in that same cycle, and no separate colour cycle exists.
- R3: In a glyph cycle, glyph_strobe is 1 and fetch_addr equals char_base + code*H + row, modulo 2^14. H is 8 when tall_glyph=0 and 16 when tall_glyph=1, code is the byte returned by the preceding code cycle, and row is the row-within-glyph counter.
- R4: The number of columns fetched is min(col_count, 32). When col_count is 0, or line_active is 0, the line has no fetch strobe at all.
- R5: No fetch strobe appears outside the column window. A window that would extend past cycle 70 is cut short at the line end.
- R6: shift_load is 1 in the cycle after each glyph fetch. In that cycle pix_bits shows glyph bits [7:4], and in the following cycle it shows bits [3:0]. pix_color shows the colour nibble fetched with that column's code.
- R7: border_out is 1, and pix_bits is 0, in any cycle with no glyph pixels pending and in any cycle whose counter value is 65 or more. The cycle of the first code fetch of a line therefore always shows border.
- R8: At the end of each active line the row counter goes up by one. When it reaches H-1 it wraps to 0 instead, and only on that wrap does the text-row base advance, by the full clamped column count.
- R9: col_count, h_start, tall_glyph and line_active are sampled in the last cycle of the previous line. A change later in a line has no effect on that line.
- R10: A frame_sync pulse sets the row counter to 0 and loads the text-row base from screen_base.
- R11: While reset is held, code_strobe, glyph_strobe and shift_load are 0, border_out is 1 and pix_bits is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock, one bus cycle per period |
| rst_n | input | 1 | Asynchronous active-low reset |
| frame_sync | input | 1 | Restart text rows from screen_base |
| line_active | input | 1 | Next line lies inside the text area |
| col_count | input | 6 | Programmed columns per text row |
| h_start | input | 7 | Cycle at which the fetch window opens |
| tall_glyph | input | 1 | 1 selects 16-row glyphs, 0 selects 8 |
| screen_base | input | 14 | Screen memory start address |
| char_base | input | 14 | Character memory start address |
| code_data | input | 8 | Character code returned by screen memory |
| color_data | input | 4 | Colour nibble returned by colour memory |
| glyph_data | input | 8 | Glyph row returned by character memory |
| fetch_addr | output | 14 | Address of the current fetch |
| code_strobe | output | 1 | Code and colour fetch this cycle |
| glyph_strobe | output | 1 | Glyph fetch this cycle |
| shift_load | output | 1 | Shifter loaded with a new glyph row |
| pix_bits | output | 4 | Four pixels for this cycle, oldest in bit 3 |
| pix_color | output | 4 | Foreground colour of the current column |
| border_out | output | 1 | Show border colour this cycle |

## Verification
A wrong cycle counter or state register moves every strobe of the next line to the wrong cycle, and a mismatch is flagged at the first fetch slot that is out of place. A wrong row counter or row base shows up at once in the next fetch address. These errors persist from line to line, so a fault in the base advance becomes visible only at the line after a glyph-height wrap. A fault in the shifter or the border logic shows in pix_bits or border_out one or two cycles after the glyph fetch it belongs to.

// File: rtl/cfs_pkg.sv
package cfs_pkg;

    typedef enum logic [1:0] {
        ST_LEAD,
        ST_CODE,
        ST_GLYPH,
        ST_TRAIL
    } fetch_state_t;

endpackage

// File: rtl/cfs_line_timer.sv
module cfs_line_timer #(
    parameter int LINE_CYCLES = 71,
    parameter int MAX_COLS    = 32,
    parameter int COL_REG_W   = 6,
    parameter int HPOS_W      = 7,
    localparam int HCNT_W     = $clog2(LINE_CYCLES),
    localparam int COL_W      = $clog2(MAX_COLS + 1)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 line_active,
    input  logic [COL_REG_W-1:0] col_count,
    input  logic [HPOS_W-1:0]    h_start,
    input  logic                 tall_glyph,
    output logic [HCNT_W-1:0]    hcnt,
    output logic [HCNT_W-1:0]    hnext,
    output logic                 line_end,
    output logic                 act_q,
    output logic [COL_W-1:0]     cols_q,
    output logic                 tall_q,
    output logic                 act_d,
    output logic [COL_W-1:0]     cols_d,
    output logic [HPOS_W-1:0]    hs_d
);

    localparam logic [HCNT_W-1:0] LAST = HCNT_W'(LINE_CYCLES - 1);

    logic [COL_W-1:0]  cols_clamped;
    logic [HPOS_W-1:0] hs_q;

    assign line_end     = (hcnt == LAST);
    assign hnext        = line_end ? '0 : hcnt + 1'b1;
    assign cols_clamped = (32'(col_count) > MAX_COLS) ? COL_W'(MAX_COLS)
                                                      : COL_W'(col_count);

    // Configuration seen by the next cycle: live inputs at the line boundary.
    assign act_d  = line_end ? line_active  : act_q;
    assign cols_d = line_end ? cols_clamped : cols_q;
    assign hs_d   = line_end ? h_start      : hs_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hcnt   <= '0;
            act_q  <= 1'b0;
            cols_q <= '0;
            hs_q   <= '0;
            tall_q <= 1'b0;
        end else begin
            hcnt <= hnext;
            if (line_end) begin
                act_q  <= line_active;
                cols_q <= cols_clamped;
                hs_q   <= h_start;
                tall_q <= tall_glyph;
            end
        end
    end

endmodule

// File: rtl/cfs_row_tracker.sv
module cfs_row_tracker #(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              frame_sync,
    input  logic [ADDR_W-1:0] screen_base,
    input  logic              line_end,
    input  logic              act_q,
    input  logic              tall_q,
    input  logic [COL_W-1:0]  cols_q,
    output logic [3:0]        row_q,
    output logic [ADDR_W-1:0] row_base
);

    logic [3:0] row_last;

    assign row_last = tall_q ? 4'd15 : 4'd7;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            row_q    <= '0;
            row_base <= '0;
        end else if (frame_sync) begin
            row_q    <= '0;
            row_base <= screen_base;
        end else if (line_end && act_q) begin
            if (row_q >= row_last) begin
                row_q    <= '0;
                row_base <= row_base + ADDR_W'(cols_q);
            end else begin
                row_q <= row_q + 4'd1;
            end
        end
    end

endmodule

// File: rtl/cfs_fetch_fsm.sv
module cfs_fetch_fsm
    import cfs_pkg::*;
#(
    parameter int ADDR_W = 14,
    parameter int COL_W  = 6,
    parameter int HCNT_W = 7,
    parameter int HPOS_W = 7
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [HCNT_W-1:0] hnext,
    input  logic              act_d,
    input  logic [COL_W-1:0]  cols_d,
    input  logic [HPOS_W-1:0] hs_d,
    input  logic [COL_W-1:0]  cols_q,
    input  logic              tall_q,
    input  logic [3:0]        row_q,
    input  logic [ADDR_W-1:0] row_base,
    input  logic [ADDR_W-1:0] char_base,
    input  logic [7:0]        code_data,
    input  logic [3:0]        color_data,
    output logic [ADDR_W-1:0] fetch_addr,
    output logic              code_strobe,
    output logic              glyph_strobe,
    output logic [3:0]        color_q,
    output logic [COL_W-1:0]  col_idx
);

    fetch_state_t      state, state_nx;
    logic [7:0]        code_q;
    logic              window_opens;
    logic              more_cols;
    logic [ADDR_W-1:0] glyph_off;

    assign window_opens = act_d && (cols_d != '0) && (HPOS_W'(hnext) == hs_d);
    assign more_cols    = (COL_W'(col_idx + 1'b1) < cols_q);
    assign glyph_off    = tall_q ? ADDR_W'({code_q, 4'b0000})
                                 : ADDR_W'({code_q, 3'b000});

    always_comb begin
        state_nx = state;
        if (line_end) begin
            state_nx = window_opens ? ST_CODE : ST_LEAD;
        end else begin
            unique case (state)
                ST_LEAD:  state_nx = window_opens ? ST_CODE : ST_LEAD;
                ST_CODE:  state_nx = ST_GLYPH;
                ST_GLYPH: state_nx = more_cols ? ST_CODE : ST_TRAIL;
                ST_TRAIL: state_nx = ST_TRAIL;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state <= ST_LEAD;
        else        state <= state_nx;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            col_idx <= '0;
            code_q  <= '0;
            color_q <= '0;
        end else begin
            if (line_end)               col_idx <= '0;
            else if (state == ST_GLYPH) col_idx <= col_idx + 1'b1;
            if (state == ST_CODE) begin
                code_q  <= code_data;
                color_q <= color_data;
            end
        end
    end

    always_comb begin
        code_strobe  = 1'b0;
        glyph_strobe = 1'b0;
        fetch_addr   = '0;
        unique case (state)
            ST_CODE: begin
                code_strobe = 1'b1;
                fetch_addr  = row_base + ADDR_W'(col_idx);
            end
            ST_GLYPH: begin
                glyph_strobe = 1'b1;
                fetch_addr   = char_base + glyph_off + ADDR_W'(row_q);
            end
            ST_LEAD, ST_TRAIL: ;
        endcase
    end

endmodule

// File: rtl/cfs_pixel_shifter.sv
module cfs_pixel_shifter #(
    parameter int HCNT_W  = 7,
    parameter int VIS_END = 65
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              line_end,
    input  logic [HCNT_W-1:0] hnext,
    input  logic              load,
    input  logic [7:0]        glyph_data,
    input  logic [3:0]        color_in,
    output logic              shift_load,
    output logic [3:0]        pix_bits,
    output logic [3:0]        pix_color,
    output logic              border_out
);

    logic [7:0] shreg;
    logic [1:0] remain;
    logic       vis_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            shreg      <= '0;
            remain     <= '0;
            vis_q      <= 1'b0;
            shift_load <= 1'b0;
            pix_color  <= '0;
        end else begin
            vis_q      <= (32'(hnext) < VIS_END);
            shift_load <= load && !line_end;
            if (line_end) begin
                remain <= '0;
            end else if (load) begin
                shreg     <= glyph_data;
                pix_color <= color_in;
                remain    <= 2'd2;
            end else if (remain != '0) begin
                shreg  <= {shreg[3:0], 4'b0000};
                remain <= remain - 2'd1;
            end
        end
    end

    assign border_out = !((remain != '0) && vis_q);
    assign pix_bits   = border_out ? 4'b0000 : shreg[7:4];

endmodule

// File: rtl/charfetch_seq.sv
module charfetch_seq #(
    parameter int LINE_CYCLES = 71,
    parameter int VIS_END     = 65,
    parameter int MAX_COLS    = 32,
    parameter int COL_REG_W   = 6,
    parameter int HPOS_W      = 7,
    parameter int ADDR_W      = 14
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 frame_sync,
    input  logic                 line_active,
    input  logic [COL_REG_W-1:0] col_count,
    input  logic [HPOS_W-1:0]    h_start,
    input  logic                 tall_glyph,
    input  logic [ADDR_W-1:0]    screen_base,
    input  logic [ADDR_W-1:0]    char_base,
    input  logic [7:0]           code_data,
    input  logic [3:0]           color_data,
    input  logic [7:0]           glyph_data,
    output logic [ADDR_W-1:0]    fetch_addr,
    output logic                 code_strobe,
    output logic                 glyph_strobe,
    output logic                 shift_load,
    output logic [3:0]           pix_bits,
    output logic [3:0]           pix_color,
    output logic                 border_out
);

    localparam int HCNT_W = $clog2(LINE_CYCLES);
    localparam int COL_W  = $clog2(MAX_COLS + 1);

    logic [HCNT_W-1:0] hcnt, hnext;
    logic              line_end;
    logic              act_q, tall_q, act_d;
    logic [COL_W-1:0]  cols_q, cols_d, col_idx;
    logic [HPOS_W-1:0] hs_d;
    logic [3:0]        row_q;
    logic [ADDR_W-1:0] row_base;
    logic [3:0]        color_q;

    cfs_line_timer #(
        .LINE_CYCLES(LINE_CYCLES), .MAX_COLS(MAX_COLS),
        .COL_REG_W(COL_REG_W), .HPOS_W(HPOS_W)
    ) u_timer (
        .clk(clk), .rst_n(rst_n), .line_active(line_active),
        .col_count(col_count), .h_start(h_start), .tall_glyph(tall_glyph),
        .hcnt(hcnt), .hnext(hnext), .line_end(line_end),
        .act_q(act_q), .cols_q(cols_q), .tall_q(tall_q),
        .act_d(act_d), .cols_d(cols_d), .hs_d(hs_d)
    );

    cfs_row_tracker #(.ADDR_W(ADDR_W), .COL_W(COL_W)) u_rows (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .screen_base(screen_base), .line_end(line_end), .act_q(act_q),
        .tall_q(tall_q), .cols_q(cols_q), .row_q(row_q), .row_base(row_base)
    );

    cfs_fetch_fsm #(
        .ADDR_W(ADDR_W), .COL_W(COL_W), .HCNT_W(HCNT_W), .HPOS_W(HPOS_W)
    ) u_fsm (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .hnext(hnext),
        .act_d(act_d), .cols_d(cols_d), .hs_d(hs_d), .cols_q(cols_q),
        .tall_q(tall_q), .row_q(row_q), .row_base(row_base),
        .char_base(char_base), .code_data(code_data), .color_data(color_data),
        .fetch_addr(fetch_addr), .code_strobe(code_strobe),
        .glyph_strobe(glyph_strobe), .color_q(color_q), .col_idx(col_idx)
    );

    cfs_pixel_shifter #(.HCNT_W(HCNT_W), .VIS_END(VIS_END)) u_pix (
        .clk(clk), .rst_n(rst_n), .line_end(line_end), .hnext(hnext),
        .load(glyph_strobe), .glyph_data(glyph_data), .color_in(color_q),
        .shift_load(shift_load), .pix_bits(pix_bits), .pix_color(pix_color),
        .border_out(border_out)
    );

endmodule

// File: rtl/cfs_checker.sv
module cfs_checker #(
    parameter int LINE_CYCLES = 71,
    parameter int MAX_COLS    = 32,
    parameter int HCNT_W      = 7,
    parameter int COL_W       = 6
) (
    input logic              clk,
    input logic              rst_n,
    input logic [HCNT_W-1:0] hcnt,
    input logic              line_end,
    input logic              code_strobe,
    input logic              glyph_strobe,
    input logic              shift_load,
    input logic              border_out,
    input logic [3:0]        pix_bits,
    input logic [COL_W-1:0]  col_idx,
    input logic [COL_W-1:0]  cols_q
);

    a_r1_line_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        line_end |=> (hcnt == '0));

    a_r1_count_range: assert property (@(posedge clk) disable iff (!rst_n)
        32'(hcnt) < LINE_CYCLES);

    a_r2_one_fetch: assert property (@(posedge clk) disable iff (!rst_n)
        !(code_strobe && glyph_strobe));

    a_r3_glyph_follows_code: assert property (@(posedge clk) disable iff (!rst_n)
        glyph_strobe |-> $past(code_strobe));

    a_r4_column_bound: assert property (@(posedge clk) disable iff (!rst_n)
        code_strobe |-> (col_idx < cols_q));

    a_r4_clamp: assert property (@(posedge clk) disable iff (!rst_n)
        32'(cols_q) <= MAX_COLS);

    a_r6_load_after_glyph: assert property (@(posedge clk) disable iff (!rst_n)
        shift_load |-> $past(glyph_strobe));

    a_r7_border_blank: assert property (@(posedge clk) disable iff (!rst_n)
        border_out |-> (pix_bits == 4'b0000));

    a_r9_config_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !line_end |=> $stable(cols_q));

endmodule

bind charfetch_seq cfs_checker #(
    .LINE_CYCLES(LINE_CYCLES), .MAX_COLS(MAX_COLS),
    .HCNT_W($clog2(LINE_CYCLES)), .COL_W($clog2(MAX_COLS + 1))
) u_chk (
    .clk(clk), .rst_n(rst_n), .hcnt(hcnt), .line_end(line_end),
    .code_strobe(code_strobe), .glyph_strobe(glyph_strobe),
    .shift_load(shift_load), .border_out(border_out), .pix_bits(pix_bits),
    .col_idx(col_idx), .cols_q(cols_q)
);

// File: tb/charfetch_seq_tb.sv
`timescale 1ns/1ps
module charfetch_seq_tb;

    localparam int LINE = 71;
    localparam int VIS  = 65;
    localparam int MASK = 16'h3FFF;
    localparam int SB   = 16'h0100;
    localparam int CB   = 16'h2000;

    typedef struct {
        int    cyc;
        int    kind;   // 0 code, 1 glyph, 2 pixel, 3 border
        int    addr;
        int    bits;
        int    color;
        bit    border;
        bit    load;
        string tag;
    } item_t;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        frame_sync = 1'b0;
    logic        line_active = 1'b0;
    logic [5:0]  col_count = '0;
    logic [6:0]  h_start = '0;
    logic        tall_glyph = 1'b0;
    logic [13:0] screen_base = '0;
    logic [13:0] char_base = '0;
    logic [7:0]  code_data, glyph_data;
    logic [3:0]  color_data;
    logic [13:0] fetch_addr;
    logic        code_strobe, glyph_strobe, shift_load, border_out;
    logic [3:0]  pix_bits, pix_color;

    item_t exp_q[$];
    int    cyc = 0;
    int    checks = 0;
    int    errors = 0;
    bit    done = 0;
    int    m_row = 0;
    int    m_base = 0;
    int    cur_line = 0;

    always #2.5 clk = ~clk;

    function automatic int code_of(int a);
        return ((a * 7 + 3) ^ (a >> 5)) & 8'hFF;
    endfunction
    function automatic int color_of(int a);
        return (a ^ (a >> 4)) & 4'hF;
    endfunction
    function automatic int glyph_of(int a);
        return ((a * 13) ^ (a >> 6) ^ 8'h5A) & 8'hFF;
    endfunction

    assign code_data  = 8'(code_of(int'(fetch_addr)));
    assign color_data = 4'(color_of(int'(fetch_addr)));
    assign glyph_data = 8'(glyph_of(int'(fetch_addr)));

    charfetch_seq u_dut (
        .clk(clk), .rst_n(rst_n), .frame_sync(frame_sync),
        .line_active(line_active), .col_count(col_count), .h_start(h_start),
        .tall_glyph(tall_glyph), .screen_base(screen_base),
        .char_base(char_base), .code_data(code_data),
        .color_data(color_data), .glyph_data(glyph_data),
        .fetch_addr(fetch_addr), .code_strobe(code_strobe),
        .glyph_strobe(glyph_strobe), .shift_load(shift_load),
        .pix_bits(pix_bits), .pix_color(pix_color), .border_out(border_out)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s at cycle %0d: actual %0h expected %0h",
                     tag, what, cyc, act, exp);
        end
    endtask

    always @(posedge clk) begin
        if (!rst_n) cyc <= 0;
        else        cyc <= cyc + 1;
    end

    // Monitor: pops expected items as their cycle comes round.
    always @(negedge clk) begin
        if (rst_n && !done) begin
            bit seen_c, seen_g;
            seen_c = 0;
            seen_g = 0;
            while (exp_q.size() > 0 && exp_q[0].cyc < cyc) begin
                item_t s;
                s = exp_q.pop_front();
                check(0, s.tag, "stale item", cyc, s.cyc);
            end
            while (exp_q.size() > 0 && exp_q[0].cyc == cyc) begin
                item_t it;
                it = exp_q.pop_front();
                case (it.kind)
                    0: begin
                        seen_c = 1;
                        check(code_strobe === 1'b1 && int'(fetch_addr) == it.addr,
                              it.tag, "code fetch", {code_strobe, fetch_addr}, {1'b1, 14'(it.addr)});
                    end
                    1: begin
                        seen_g = 1;
                        check(glyph_strobe === 1'b1 && int'(fetch_addr) == it.addr,
                              it.tag, "glyph fetch", {glyph_strobe, fetch_addr}, {1'b1, 14'(it.addr)});
                    end
                    2: begin
                        if (it.border)
                            check(border_out === 1'b1 && pix_bits === 4'h0, it.tag,
                                  "cropped pixels", {border_out, pix_bits}, 5'h10);
                        else
                            check(border_out === 1'b0 && int'(pix_bits) == it.bits &&
                                  int'(pix_color) == it.color && shift_load === it.load,
                                  it.tag, "pixels",
                                  {border_out, pix_bits, pix_color, shift_load},
                                  {1'b0, 4'(it.bits), 4'(it.color), it.load});
                    end
                    default: begin
                        check(border_out === 1'b1, it.tag, "border", border_out, 1);
                    end
                endcase
            end
            if (code_strobe && !seen_c) check(0, "R5", "unexpected code strobe", fetch_addr, 0);
            if (glyph_strobe && !seen_g) check(0, "R5", "unexpected glyph strobe", fetch_addr, 0);
        end
    end

    task automatic wait_cycle(input int t);
        while (cyc < t) begin
            @(posedge clk);
            #1;
        end
    endtask

    // Driver: expected schedule of one line from the requirements.
    task automatic push_line(input int L, input bit act, input int cols,
                             input int hs, input bit tall, input string tag);
        int eff, hh;
        eff = (cols > 32) ? 32 : cols;
        hh  = tall ? 16 : 8;
        if (!act) return;
        for (int h = 0; h < LINE; h++) begin
            int rel, p;
            item_t it;
            it = '{cyc: L * LINE + h, kind: 0, addr: 0, bits: 0, color: 0,
                   border: 0, load: 0, tag: tag};
            rel = h - hs;
            if (h == hs && eff > 0) begin
                it.kind = 3; it.tag = "R7";
                exp_q.push_back(it);
                it.tag = tag;
            end
            if (rel >= 0 && rel / 2 < eff) begin
                int ca;
                ca = (m_base + rel / 2) & MASK;
                if (rel % 2 == 0) begin
                    it.kind = 0; it.addr = ca;
                end else begin
                    it.kind = 1; it.tag = "R3";
                    it.addr = (CB + code_of(ca) * hh + m_row) & MASK;
                end
                exp_q.push_back(it);
            end
            p = rel - 2;
            if (p >= 0 && p / 2 < eff) begin
                int ca, g;
                ca = (m_base + p / 2) & MASK;
                g  = glyph_of((CB + code_of(ca) * hh + m_row) & MASK);
                it.kind   = 2;
                it.load   = (p % 2 == 0);
                it.bits   = it.load ? (g >> 4) : (g & 15);
                it.color  = color_of(ca);
                it.border = (h >= VIS);
                it.tag    = it.border ? "R7" : "R6";
                exp_q.push_back(it);
            end
        end
        if (act) begin
            if (m_row >= hh - 1) begin
                m_row = 0;
                m_base = (m_base + eff) & MASK;
            end else begin
                m_row++;
            end
        end
    endtask

    task automatic cfg_line(input bit act, input int cols, input int hs,
                            input bit tall, input string tag,
                            input bit glitch, input int gcols);
        wait_cycle(cur_line * LINE + 40);
        line_active = act;
        col_count   = 6'(cols);
        h_start     = 7'(hs);
        tall_glyph  = tall;
        push_line(cur_line + 1, act, cols, hs, tall, tag);
        cur_line++;
        if (glitch) begin
            wait_cycle(cur_line * LINE + 20);
            col_count = 6'(gcols);
        end
    endtask

    initial begin
        repeat (4) @(posedge clk);
        @(negedge clk);
        // R11 reset state
        check(code_strobe === 1'b0 && glyph_strobe === 1'b0, "R11", "strobes in reset",
              {code_strobe, glyph_strobe}, 0);
        check(shift_load === 1'b0 && border_out === 1'b1 && pix_bits === 4'h0, "R11",
              "pixel outputs in reset", {shift_load, border_out, pix_bits}, 5'h10);
        @(posedge clk);
        #1 rst_n = 1'b1;
        screen_base = 14'(SB);
        char_base   = 14'(CB);

        // R10 frame restart during the idle first line
        wait_cycle(30);
        frame_sync = 1'b1;
        wait_cycle(31);
        frame_sync = 1'b0;
        m_row = 0;
        m_base = SB;

        cfg_line(1, 5, 4, 0, "R10", 0, 0);
        for (int i = 0; i < 7; i++) cfg_line(1, 5, 4, 0, "R8", 0, 0);
        cfg_line(1, 5, 0, 0, "R1", 0, 0);           // window at cycle 0, base advanced
        cfg_line(0, 5, 4, 0, "R4", 0, 0);           // inactive line
        cfg_line(1, 0, 4, 0, "R4", 0, 0);           // zero columns
        cfg_line(1, 3, 30, 0, "R9", 1, 20);         // mid-line write to 20
        cfg_line(1, 9, 30, 0, "R9", 0, 0);
        cfg_line(1, 40, 9, 1, "R4", 0, 0);          // clamp, crop, tall glyphs
        for (int i = 0; i < 15; i++) cfg_line(1, 40, 9, 1, "R5", 0, 0);
        cfg_line(1, 7, 2, 0, "R8", 0, 0);
        cfg_line(0, 7, 2, 0, "R4", 0, 0);

        wait_cycle((cur_line + 1) * LINE + 5);
        while (exp_q.size() > 0) begin
            item_t it;
            it = exp_q.pop_front();
            check(0, it.tag, "item never reached", cyc, it.cyc);
        end
        done = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected finished");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

endmodule